// File: doc/BRIEF.md
# Clock Rate Offset Corrector

This block trims the rate of a timekeeping chain. It sits between the prescaler, which produces a stream of divider pulses, and the seconds counter. At scheduled points it either adds pulses to the stream or deletes pulses from it. The schedule comes from an 8-bit trim code and from the calendar's current hour, minute and second-zero flag. Each code unit is worth about 2170 ppb.

A correction always falls inside the first second of a selected minute. With a code magnitude n, minutes 0 to n-1 of the hour are selected. Magnitudes above 60 cannot be spread over more minutes, so the extra corrections go into the last minute of the hour. The fine mode acts only in even hours. The coarse mode acts in every hour, so each coarse unit has twice the effect of a fine unit. A new trim code is adopted only when the hour changes, so no hour is ever partly corrected.

Top module: `rate_trim_top`

## Requirements
- R1: The trim code carries a two's complement amount in bits 6..0 and the mode in bit 7 (0 = fine, 1 = coarse). The magnitude runs from 0 to 64.
- R2: For a positive amount, each correction adds one output pulse in a cycle where `tick_i` is low. For a negative amount, each correction removes one input pulse. Within a window, a positive code never removes a pulse and a negative code never adds one.
- R3: In a minute k below 59, exactly one correction is applied when k is less than the magnitude. Otherwise none is applied.
- R4: In minute 59 the number of corrections is the magnitude minus 59 when the magnitude is 60 or more, and zero otherwise. So 60 gives 1, 61 gives 2, 62 gives 3, 63 gives 4 and -64 gives 5. No other minute receives more than one correction.
- R5: In fine mode, corrections are applied only when the hour is even. In coarse mode they are applied in every hour.
- R6: A zero amount leaves the pulse stream unchanged in both modes.
- R7: The trim code is captured in the cycle where `hour_i` changes value. A code written in the middle of an hour has no effect until the next hour change. After reset the captured code is zero.
- R8: The correction window opens on the cycle after `sec_zero_i` rises and closes when it falls. Unused corrections are discarded when the window closes. Outside the window, `tick_o` equals `tick_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| offset_code_i | input | 8 | Trim code: mode in bit 7, signed amount in bits 6..0 |
| hour_i | input | HOUR_W (5) | Calendar hour, 0 to 23, binary |
| minute_i | input | MIN_W (6) | Calendar minute, 0 to 59, binary |
| sec_zero_i | input | 1 | High while the calendar seconds value is zero |
| tick_i | input | 1 | Divider pulse from the prescaler, one cycle wide |
| tick_o | output | 1 | Corrected pulse stream to the seconds counter |

## Verification
Every internal fault shows up as a wrong count of `tick_o` pulses within the one-second window in which it matters:
- A wrong correction budget, direction or captured code shows within that same window.
- A stale or missing code capture shows in the first window after an hour change.
- A budget that is not cleared shows as a pulse difference right after `sec_zero_i` falls.

The vectors compare the pulse count of each window against a count worked out by hand from the minute, hour parity, mode and magnitude.

// File: rtl/rate_trim_pkg.sv
package rate_trim_pkg;
   localparam int TRIM_VAL_W = 7;
   localparam int TRIM_W     = TRIM_VAL_W + 1;

   typedef struct packed {
      logic                  neg;
      logic                  coarse;
      logic [TRIM_VAL_W-1:0] mag;
   } trim_dec_t;
endpackage

// File: rtl/trim_decode.sv
module trim_decode
   import rate_trim_pkg::*;
(
   input  logic [TRIM_W-1:0] code_i,
   output trim_dec_t         dec_o
);
   logic [TRIM_VAL_W-1:0] val;

   always_comb begin
      val          = code_i[TRIM_VAL_W-1:0];
      dec_o.coarse = code_i[TRIM_W-1];
      dec_o.neg    = val[TRIM_VAL_W-1];
      // the negated most negative value wraps to its own magnitude
      dec_o.mag    = dec_o.neg ? (~val + 1'b1) : val;
   end
endmodule

// File: rtl/trim_schedule.sv
module trim_schedule
   import rate_trim_pkg::*;
#(
   parameter int HOUR_W           = 5,
   parameter int MIN_W            = 6,
   parameter int MINUTES_PER_HOUR = 60
) (
   input  trim_dec_t             dec_i,
   input  logic [HOUR_W-1:0]     hour_i,
   input  logic [MIN_W-1:0]      minute_i,
   output logic [TRIM_VAL_W-1:0] count_o
);
   localparam int LAST_MIN = MINUTES_PER_HOUR - 1;

   always_comb begin
      int m;
      int n;
      m       = int'(minute_i);
      n       = int'(dec_i.mag);
      count_o = '0;
      if (dec_i.coarse || !hour_i[0]) begin
         if (m < LAST_MIN) begin
            if (m < n) count_o = TRIM_VAL_W'(1);
         end else if (m == LAST_MIN && n > LAST_MIN) begin
            count_o = TRIM_VAL_W'(n - LAST_MIN);
         end
      end
   end
endmodule

// File: rtl/pulse_shaper.sv
module pulse_shaper #(
   parameter int BUD_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_zero_i,
   input  logic             tick_i,
   input  logic [BUD_W-1:0] load_cnt_i,
   input  logic             load_neg_i,
   output logic             tick_o
);
   logic             sec_q;
   logic             neg_q;
   logic [BUD_W-1:0] budget;
   logic             act;

   assign act    = sec_zero_i && (budget != '0);
   assign tick_o = neg_q ? (tick_i && !act) : (tick_i || act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q  <= 1'b0;
         neg_q  <= 1'b0;
         budget <= '0;
      end else begin
         sec_q <= sec_zero_i;
         if (sec_zero_i && !sec_q) begin
            budget <= load_cnt_i;
            neg_q  <= load_neg_i;
         end else if (!sec_zero_i) begin
            budget <= '0;
         end else if (act && (neg_q == tick_i)) begin
            budget <= budget - 1'b1;
         end
      end
   end

   p_no_add_on_remove_r2: assert property (@(posedge clk) disable iff (!rst_n)
      neg_q |-> !(tick_o && !tick_i));
   p_no_drop_on_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !neg_q |-> !(tick_i && !tick_o));
   p_pass_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_zero_i |-> (tick_o == tick_i));
   p_budget_falls_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_zero_i && sec_q) |=> (budget <= $past(budget)));
   p_leftover_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_zero_i |=> (budget == '0));
endmodule

// File: rtl/rate_trim_top.sv
module rate_trim_top
   import rate_trim_pkg::*;
#(
   parameter int HOUR_W           = 5,
   parameter int MIN_W            = 6,
   parameter int MINUTES_PER_HOUR = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        offset_code_i,
   input  logic [HOUR_W-1:0] hour_i,
   input  logic [MIN_W-1:0]  minute_i,
   input  logic              sec_zero_i,
   input  logic              tick_i,
   output logic              tick_o
);
   localparam int LAST_MIN = MINUTES_PER_HOUR - 1;

   initial begin
      assert (TRIM_W == 8) else $error("trim code must be 8 bits");
      assert (MINUTES_PER_HOUR <= (1 << MIN_W)) else $error("MIN_W too small");
      assert (LAST_MIN < (1 << TRIM_VAL_W)) else $error("hour too long for code");
      assert (HOUR_W >= 1) else $error("HOUR_W must be positive");
   end

   logic [HOUR_W-1:0]     hour_q;
   logic                  hour_vld;
   logic [TRIM_W-1:0]     active;
   logic                  hour_chg;
   logic [TRIM_W-1:0]     eff_code;
   trim_dec_t             dec;
   logic [TRIM_VAL_W-1:0] cnt;

   assign hour_chg = hour_vld && (hour_i != hour_q);
   assign eff_code = hour_chg ? offset_code_i : active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hour_q   <= '0;
         hour_vld <= 1'b0;
         active   <= '0;
      end else begin
         hour_q   <= hour_i;
         hour_vld <= 1'b1;
         if (hour_chg) active <= offset_code_i;
      end
   end

   trim_decode i_dec (
      .code_i (eff_code),
      .dec_o  (dec)
   );

   trim_schedule #(
      .HOUR_W           (HOUR_W),
      .MIN_W            (MIN_W),
      .MINUTES_PER_HOUR (MINUTES_PER_HOUR)
   ) i_sched (
      .dec_i    (dec),
      .hour_i   (hour_i),
      .minute_i (minute_i),
      .count_o  (cnt)
   );

   pulse_shaper #(
      .BUD_W (TRIM_VAL_W)
   ) i_shape (
      .clk        (clk),
      .rst_n      (rst_n),
      .sec_zero_i (sec_zero_i),
      .tick_i     (tick_i),
      .load_cnt_i (cnt),
      .load_neg_i (dec.neg),
      .tick_o     (tick_o)
   );

   p_code_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hour_vld && hour_i == hour_q) |=> (active == $past(active)));
   p_fold_last_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt > TRIM_VAL_W'(1)) |-> (int'(minute_i) == LAST_MIN));
   p_zero_no_corr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_code[TRIM_VAL_W-1:0] == '0) |-> (cnt == '0));
endmodule

// File: tb/test_rate_trim_top.sv
module test_rate_trim_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] code = 8'h00;
   logic [4:0] hour = 5'd0;
   logic [5:0] minute = 6'd0;
   logic       sz = 1'b0;
   logic       tk = 1'b0;
   logic       tko;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   rate_trim_top i_rate_trim_top (
      .clk(clk), .rst_n(rst_n), .offset_code_i(code), .hour_i(hour),
      .minute_i(minute), .sec_zero_i(sz), .tick_i(tk), .tick_o(tko)
   );

   // code, hour, minute, expected pulses in a 16-cycle window carrying 8 input ticks
   localparam int NV = 12;
   localparam logic [7:0] V_CODE [NV] = '{8'h05, 8'h05, 8'h05, 8'h85, 8'h7B, 8'h3F,
                                          8'h3D, 8'h3C, 8'h40, 8'h00, 8'hC1, 8'h3F};
   localparam int V_HOUR [NV] = '{2, 2, 3, 3, 4, 6, 8, 8, 10, 0, 7, 6};
   localparam int V_MIN  [NV] = '{3, 5, 0, 4, 0, 59, 59, 59, 59, 0, 59, 58};
   localparam int V_EXP  [NV] = '{9, 8, 8, 9, 7, 12, 10, 9, 3, 8, 4, 9};
   localparam string V_REQ [NV] = '{"R3", "R3", "R5", "R5", "R2", "R4",
                                    "R4", "R4", "R1", "R6", "R1", "R3"};

   task automatic cyc(input logic s, input logic t, inout int cnt);
      @(negedge clk);
      sz = s;
      tk = t;
      #1;
      if (tko) cnt++;
   endtask

   task automatic set_hour(input logic [7:0] c, input int h);
      int d = 0;
      code = c;
      cyc(1'b0, 1'b0, d);
      hour = 5'((h + 1) % 24);
      cyc(1'b0, 1'b0, d);
      hour = 5'(h);
      cyc(1'b0, 1'b0, d);
      cyc(1'b0, 1'b0, d);
   endtask

   task automatic window(input int len, output int cnt);
      cnt = 0;
      for (int i = 0; i < len; i++) cyc(1'b1, 1'(i % 2), cnt);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int c;
      // R7: reset state, code on input but nothing captured yet
      code = 8'h05;
      hour = 5'd2;
      minute = 6'd0;
      repeat (3) @(negedge clk);
      c = 0;
      cyc(1'b0, 1'b1, c);
      check("R7", c, 1);
      rst_n = 1'b1;
      cyc(1'b0, 1'b0, c);
      window(16, c);
      check("R7", c, 8);
      cyc(1'b0, 1'b0, c);

      for (int v = 0; v < NV; v++) begin
         set_hour(V_CODE[v], V_HOUR[v]);
         minute = 6'(V_MIN[v]);
         window(16, c);
         check(V_REQ[v], c, V_EXP[v]);
      end

      // R7: a mid-hour write is ignored until the hour changes
      set_hour(8'h05, 2);
      code = 8'h7B;
      minute = 6'd0;
      window(16, c);
      check("R7", c, 9);
      cyc(1'b0, 1'b0, c);
      set_hour(8'h7B, 4);
      window(16, c);
      check("R7", c, 7);

      // R8: a short window discards leftovers; ticks then pass through
      set_hour(8'h3F, 6);
      minute = 6'd59;
      window(2, c);
      check("R8", c, 1);
      c = 0;
      for (int i = 0; i < 8; i++) cyc(1'b0, 1'(i % 2), c);
      check("R8", c, 4);

      // R6: zero amount in coarse mode
      set_hour(8'h80, 5);
      minute = 6'd0;
      window(16, c);
      check("R6", c, 8);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule